// File: doc/BRIEF.md
# Fast-Write Throttle and Disconnect Controller

This block manages block-level flow control on an unbounded-length fast-write transfer. It sits on the receiving side. While a transfer is running, it keeps an internal count of accepted data beats. After every `BLOCK_BEATS` accepted beats it reaches a throttle point. At each throttle point it checks whether its receive buffer can take a whole block. If it can, target-ready stays high with no wait. If it cannot, it holds target-ready low for one wait cycle, counted from the throttle point, and checks again on a second cycle. If space is still short on that second cycle, it signals a disconnect instead of stalling any longer.

For the sending side, the block also keeps a byte offset. The offset advances by the data width on every accepted beat. It is kept through a disconnect, so a transfer that restarts while the request is still pending continues from exactly the byte where the previous one stopped. The offset is cleared only when no transfer is pending. A monitor output reports any stall of three or more consecutive cycles. In correct operation it never fires.

States:
- `ST_IDLE`: no transfer in progress.
- `ST_THROTTLE`: the throttle-point cycle.
- `ST_HOLD`: the second wait cycle.
- `ST_STREAM`: data flows inside a block.

Transitions:
- idle to throttle, on a request.
- throttle to stream, when space is enough.
- throttle to hold, when space is short.
- hold to stream, when space has arrived.
- hold to idle, when a disconnect is signalled.
- stream to throttle, on the last beat of a block.
- any state to idle, when the request drops.

A throttle or hold cycle that accepts the final beat of a block returns directly to throttle.

Top module: `fwt_ctl`

## Requirements
- R1: After reset, and while `fw_req` stays low, `tgt_rdy`, `disc` and `stall_err` are 0 and `resume_off` is 0.
- R2: A throttle point occurs in the first cycle after `fw_req` is seen high while idle, and again in the cycle after the `BLOCK_BEATS`-th accepted beat of each block. In a throttle-point cycle, `tgt_rdy` is 1 in that same cycle exactly when `buf_space >= BLOCK_BEATS`. In the idle cycle that sees the request, `tgt_rdy` is 0.
- R3: If space is short at a throttle point, `tgt_rdy` is 0 for that cycle. In the following cycle, `tgt_rdy` is 1 if `buf_space >= BLOCK_BEATS`, and the block then proceeds normally.
- R4: If space is still short in that second cycle, `disc` is 1 for that one cycle and `tgt_rdy` stays 0. The next cycle is idle, with `tgt_rdy` at 0, and `tgt_rdy` is never 0 for more than two consecutive cycles of an active transfer.
- R5: Between throttle points, `tgt_rdy` stays 1 whatever the values of `buf_space` and `beat_vld`.
- R6: `resume_off` grows by `DATA_BYTES` at each clock edge where `beat_vld`, `tgt_rdy` and `fw_req` are all 1. At every other edge with `fw_req` high, it is unchanged.
- R7: Across a disconnect with `fw_req` kept high, `resume_off` is held. The restarted transfer opens with a new throttle point and continues counting from the held value.
- R8: At each clock edge where `fw_req` is 0, `resume_off` is cleared, so a fresh transfer starts at offset 0.
- R9: `stall_err` is 1 in any active-transfer cycle that is the third or later consecutive cycle with `tgt_rdy` low. In correct operation it stays 0.
- R10: If `fw_req` drops during a transfer, the controller is idle in the next cycle, with `tgt_rdy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fw_req | input | 1 | Fast-write transfer pending (level) |
| beat_vld | input | 1 | Data beat valid from the sender |
| buf_space | input | SPACE_W | Free receive-buffer entries, in beats |
| tgt_rdy | output | 1 | Receiver ready; a beat is accepted when high with `beat_vld` |
| disc | output | 1 | One-cycle disconnect of a stalled transfer |
| resume_off | output | OFF_W | Byte offset of the next beat to be sent |
| stall_err | output | 1 | Stall of three or more cycles detected |

## Verification
The hardest situation to reach from the ports is a disconnect that lands in the middle of a transfer, with a non-zero offset, followed by a resume from that exact offset. To get there, the stimulus first streams whole blocks, so the offset grows past several block boundaries. It then withdraws buffer space at the exact cycle of a throttle point and keeps it short, one entry below a block, through the second wait cycle. It holds `beat_vld` high the whole time, so that any wrongly accepted beat would show up in the offset. The request is kept high across the disconnect, and the restarted transfer is checked to open at the held offset before the request is dropped and the offset is seen to clear.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_THROTTLE = 2'd1,
        ST_HOLD     = 2'd2,
        ST_STREAM   = 2'd3
    } fwt_state_e;
endpackage

// File: rtl/fwt_seq.sv
module fwt_seq
    import fwt_pkg::*;
#(
    parameter int BLOCK_BEATS = 8,
    parameter int SPACE_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fw_req,
    input  logic               beat_vld,
    input  logic [SPACE_W-1:0] buf_space,
    output logic               tgt_rdy,
    output logic               disc,
    output logic               active
);
    localparam int CNT_W = (BLOCK_BEATS > 1) ? $clog2(BLOCK_BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_BEATS - 1);

    fwt_state_e       state_q, state_d;
    logic [CNT_W-1:0] blk_cnt_q;
    logic             space_ok;
    logic             accept;
    logic             blk_last;

    assign space_ok = (int'(buf_space) >= BLOCK_BEATS);
    assign accept   = beat_vld && tgt_rdy;
    assign blk_last = (blk_cnt_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // beat position inside the current block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blk_cnt_q <= '0;
        else if (state_q == ST_IDLE || !fw_req)
            blk_cnt_q <= '0;
        else if (accept)
            blk_cnt_q <= blk_last ? '0 : blk_cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (state_q != ST_IDLE && !fw_req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (fw_req) state_d = ST_THROTTLE;
                ST_THROTTLE: begin
                    if (space_ok) state_d = (accept && blk_last) ? ST_THROTTLE : ST_STREAM;
                    else          state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (space_ok) state_d = (accept && blk_last) ? ST_THROTTLE : ST_STREAM;
                    else          state_d = ST_IDLE;
                end
                ST_STREAM:   if (accept && blk_last) state_d = ST_THROTTLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tgt_rdy = 1'b0;
        disc    = 1'b0;
        unique case (state_q)
            ST_IDLE:     tgt_rdy = 1'b0;
            ST_THROTTLE: tgt_rdy = space_ok;
            ST_HOLD: begin
                tgt_rdy = space_ok;
                disc    = !space_ok && fw_req;
            end
            ST_STREAM:   tgt_rdy = 1'b1;
            default:     tgt_rdy = 1'b0;
        endcase
    end

    assign active = (state_q != ST_IDLE);

    // R4: no third consecutive low-ready cycle inside a transfer
    assert_two_wait_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tgt_rdy) ##1 (active && !tgt_rdy) |=> !(active && !tgt_rdy));

    // R4: disconnect only when space is short, and never with ready high
    assert_disc_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disc |-> (int'(buf_space) < BLOCK_BEATS) && !tgt_rdy);

    // R4: the cycle after a disconnect is idle
    assert_disc_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disc |=> !active && !tgt_rdy);

    // R10: dropping the request ends the transfer
    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_req |=> !active);
endmodule

// File: rtl/fwt_offset.sv
module fwt_offset #(
    parameter int DATA_BYTES = 8,
    parameter int OFF_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fw_req,
    input  logic             beat_vld,
    input  logic             tgt_rdy,
    input  logic             disc,
    output logic [OFF_W-1:0] resume_off
);
    localparam logic [OFF_W-1:0] STEP = OFF_W'(DATA_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resume_off <= '0;
        else if (!fw_req)
            resume_off <= '0;
        else if (beat_vld && tgt_rdy)
            resume_off <= resume_off + STEP;
    end

    // R6: each accepted beat moves the offset by one data width
    assert_off_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_req && beat_vld && tgt_rdy) |=> resume_off == $past(resume_off) + STEP);

    // R7: offset held over a disconnect while the request remains
    assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disc && fw_req) |=> $stable(resume_off));

    // R8: no pending transfer clears the offset
    assert_off_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_req |=> resume_off == '0);
endmodule

// File: rtl/fwt_stall_mon.sv
module fwt_stall_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tgt_rdy,
    output logic stall_err
);
    logic [1:0] low_run_q;
    logic       stalled;

    assign stalled = active && !tgt_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run_q <= 2'd0;
        else if (stalled)
            low_run_q <= (low_run_q == 2'd2) ? 2'd2 : low_run_q + 2'd1;
        else
            low_run_q <= 2'd0;
    end

    assign stall_err = stalled && (low_run_q == 2'd2);

    // R9: the flag never rises on a conforming controller
    assert_no_long_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_err);
endmodule

// File: rtl/fwt_ctl.sv
module fwt_ctl #(
    parameter int BLOCK_BEATS = 8,
    parameter int DATA_BYTES  = 8,
    parameter int SPACE_W     = 8,
    parameter int OFF_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fw_req,
    input  logic               beat_vld,
    input  logic [SPACE_W-1:0] buf_space,
    output logic               tgt_rdy,
    output logic               disc,
    output logic [OFF_W-1:0]   resume_off,
    output logic               stall_err
);
    logic active;

    fwt_seq #(
        .BLOCK_BEATS (BLOCK_BEATS),
        .SPACE_W     (SPACE_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fw_req    (fw_req),
        .beat_vld  (beat_vld),
        .buf_space (buf_space),
        .tgt_rdy   (tgt_rdy),
        .disc      (disc),
        .active    (active)
    );

    fwt_offset #(
        .DATA_BYTES (DATA_BYTES),
        .OFF_W      (OFF_W)
    ) off_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fw_req     (fw_req),
        .beat_vld   (beat_vld),
        .tgt_rdy    (tgt_rdy),
        .disc       (disc),
        .resume_off (resume_off)
    );

    fwt_stall_mon mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tgt_rdy   (tgt_rdy),
        .stall_err (stall_err)
    );

    // R1: nothing is driven while no transfer is pending
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fw_req && !active) |-> !tgt_rdy && !disc);
endmodule

// File: tb/fwt_ctl_tb_top.sv
module fwt_ctl_tb_top;
    localparam int BB    = 4;
    localparam int DB    = 8;
    localparam int SW    = 8;
    localparam int OW    = 16;

    typedef struct {
        logic          rdy;
        logic          dsc;
        logic [OW-1:0] off;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fw_req = 1'b0;
    logic          beat_vld = 1'b0;
    logic [SW-1:0] buf_space = '0;
    logic          tgt_rdy, disc, stall_err;
    logic [OW-1:0] resume_off;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    fwt_ctl #(
        .BLOCK_BEATS (BB),
        .DATA_BYTES  (DB),
        .SPACE_W     (SW),
        .OFF_W       (OW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fw_req     (fw_req),
        .beat_vld   (beat_vld),
        .buf_space  (buf_space),
        .tgt_rdy    (tgt_rdy),
        .disc       (disc),
        .resume_off (resume_off),
        .stall_err  (stall_err)
    );

    // driver: apply one cycle of stimulus and queue what must be seen in it
    task automatic step(input logic rq, input logic vl, input int sp,
                        input logic e_rdy, input logic e_dsc, input int e_off,
                        input string tag);
        exp_t it;
        @(negedge clk);
        fw_req    = rq;
        beat_vld  = vl;
        buf_space = SW'(sp);
        it.rdy = e_rdy;
        it.dsc = e_dsc;
        it.off = OW'(e_off);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare late in each cycle, well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (tgt_rdy !== it.rdy) begin
                    failures++;
                    $display("FAIL %s tgt_rdy actual=%0b expected=%0b", it.tag, tgt_rdy, it.rdy);
                end
                checks++;
                if (disc !== it.dsc) begin
                    failures++;
                    $display("FAIL %s disc actual=%0b expected=%0b", it.tag, disc, it.dsc);
                end
                checks++;
                if (resume_off !== it.off) begin
                    failures++;
                    $display("FAIL %s resume_off actual=%0d expected=%0d", it.tag, resume_off, it.off);
                end
                checks++;
                if (stall_err !== 1'b0) begin
                    failures++;
                    $display("FAIL R9 stall_err actual=%0b expected=0 (%s)", stall_err, it.tag);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                // R1: quiet after reset
                step(0, 0, 8, 0, 0,  0, "R1");
                step(0, 1, 8, 0, 0,  0, "R1");
                // R2: request seen while idle, ready not yet given
                step(1, 1, 8, 0, 0,  0, "R2");
                // R2: throttle point with room for a block
                step(1, 1, 8, 1, 0,  0, "R2");
                step(1, 1, 8, 1, 0,  8, "R6");
                step(1, 1, 8, 1, 0, 16, "R6");
                step(1, 1, 8, 1, 0, 24, "R6");
                // R3: short at throttle point, space arrives on second cycle (exactly BB)
                step(1, 0, 2, 0, 0, 32, "R3");
                step(1, 1, 4, 1, 0, 32, "R3");
                // R5: inside a block ready ignores buffer space and valid gaps
                step(1, 0, 0, 1, 0, 40, "R5");
                step(1, 1, 0, 1, 0, 40, "R5");
                step(1, 1, 0, 1, 0, 48, "R5");
                step(1, 1, 8, 1, 0, 56, "R6");
                // R4: short on both cycles -> disconnect, no beat taken
                step(1, 1, 0, 0, 0, 64, "R4");
                step(1, 1, 3, 0, 1, 64, "R4");
                // R7: idle one cycle, then resume at the held offset
                step(1, 1, 8, 0, 0, 64, "R7");
                step(1, 1, 8, 1, 0, 64, "R7");
                step(1, 1, 8, 1, 0, 72, "R7");
                // R10: request drops mid-block
                step(0, 0, 8, 1, 0, 80, "R10");
                step(0, 0, 8, 0, 0,  0, "R10");
                // R8: fresh transfer starts from zero
                step(1, 1, 4, 0, 0,  0, "R8");
                step(1, 1, 4, 1, 0,  0, "R2");
                step(1, 0, 0, 1, 0,  8, "R5");
                step(0, 0, 0, 1, 0,  8, "R10");
                step(0, 0, 0, 0, 0,  0, "R8");
                repeat (3) @(negedge clk);
            end
            begin
                repeat (2000) @(posedge clk);
                if (!done) begin
                    checks++;
                    failures++;
                    $display("FAIL watchdog expired actual=timeout expected=completion");
                end
            end
        join_any
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule